// File: doc/BRIEF.md
# GPIO Port Register Block

A general-purpose I/O port controller for a configurable number of pins (16 by default). It sits behind a simple memory-mapped register bus. The bus has an address, write data, write and read strobes, an access-size code, read data, and an error flag. The block holds five registers:

- a function-enable mask,
- an output data word,
- a direction word,
- an input-enable mask,
- a 32-bit multiplex-select word. This word is only stored and exported; no routing is done here.

Software changes the data word by a plain write or through set and clear aliases. It changes the direction word only through set and clear aliases.

Each pin gets an output value and an output enable. Both are derived from the data, direction and input-enable words. A pin's input level is admitted only when three conditions hold: the pin is an input, its input is enabled, and its function is enabled. Admitted levels pass through a two-flop synchronizer into a read-only input-level register. Every access completes in one cycle. The read data and the error flag are registered and valid in the cycle after the strobe.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every register (function-enable, data, direction, input-enable, mux, input-level) is zero, `pin_out`, `pin_oe` and `mux_sel` are zero, and `bus_err` is low.
- R2: Offsets 0x00 (function-enable), 0x18 (input-enable) and 0x1C (mux, 32 bits) are written plainly and read back the stored value.
- R3: A write to 0x04 loads the data word. A write to 0x08 ORs the written bits into it. A write to 0x0C clears every data bit written as 1. Reads of 0x04, 0x08 and 0x0C all return the data word.
- R4: The direction word changes only through 0x10 (OR in ones) and 0x14 (clear bits written as one). Reads of either offset return the direction word.
- R5: Size codes on `bus_size` are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The mux register needs code 2 and every other register needs code 1. With any other code, `bus_err` is raised, a write has no effect and a read returns zero.
- R6: An access whose address has non-zero bits [1:0], or whose offset lies above 0x20, raises `bus_err`, changes nothing, and reads zero.
- R7: The input-level register at 0x20 is read-only (2-byte reads). A write to it raises `bus_err` and leaves it unchanged.
- R8: `pin_out[i]` equals data bit i when input-enable bit i is 0, and is 0 when input-enable bit i is 1.
- R9: `pin_oe[i]` is 1 exactly when direction bit i is 1 and input-enable bit i is 0.
- R10: Input-level bit i follows `pin_in[i]`, through a two-flop synchronizer plus one register stage, only while direction bit i is 0, input-enable bit i is 1 and function-enable bit i is 1. Otherwise the bit keeps its last value.
- R11: `bus_err` and `bus_rdata` for an access appear in the cycle after the strobe. `bus_err` stays high for that cycle only and is never raised without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 2 | Access size code: 0 = byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error pulse for an illegal access |
| pin_in | input | PINS | External pin levels |
| pin_out | output | PINS | Per-pin output value |
| pin_oe | output | PINS | Per-pin output enable |
| mux_sel | output | 32 | Stored multiplex-select word |

## Verification
The bench builds the block with its defaults: 16 pins and a 6-bit address. With these values, the highest pin, bit 15, can be seen on every output and register. The address space also reaches offsets 0x24 to 0x3C, which lie above the map and so exercise the unmapped path. The bench sets the mask registers so that only some pins meet the three-way admission condition. This shows admitted and held bits side by side in one input-level read.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared register identifiers and size codes for the GPIO port block.
// Assumes a 32-bit bus data path and a 4-byte register stride.
package gpio_port_pkg;

    localparam int BUS_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [3:0] {
        REG_FER    = 4'd0,
        REG_DATA   = 4'd1,
        REG_DSET   = 4'd2,
        REG_DCLR   = 4'd3,
        REG_DIRSET = 4'd4,
        REG_DIRCLR = 4'd5,
        REG_INEN   = 4'd6,
        REG_MUX    = 4'd7,
        REG_LVL    = 4'd8,
        REG_NONE   = 4'd15
    } reg_id_e;

endpackage

// File: rtl/gpio_bus_decode.sv
// Module gpio_bus_decode
// Maps a byte offset and size code to a register identifier and
// flags legal reads and writes. Purely combinational.
// Assumes registers on a 4-byte stride starting at offset 0.
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_id_e           reg_id,
    output logic              legal_rd,
    output logic              legal_wr
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             size_ok;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Translate the word index into a register identifier.
    always_comb begin
        case (idx)
            IDX_W'(0): reg_id = REG_FER;
            IDX_W'(1): reg_id = REG_DATA;
            IDX_W'(2): reg_id = REG_DSET;
            IDX_W'(3): reg_id = REG_DCLR;
            IDX_W'(4): reg_id = REG_DIRSET;
            IDX_W'(5): reg_id = REG_DIRCLR;
            IDX_W'(6): reg_id = REG_INEN;
            IDX_W'(7): reg_id = REG_MUX;
            IDX_W'(8): reg_id = REG_LVL;
            default:   reg_id = REG_NONE;
        endcase
    end

    // The mux word needs a 4-byte access; everything else needs 2 bytes.
    always_comb begin
        size_ok  = (reg_id == REG_MUX) ? (size == SZ_WORD) : (size == SZ_HALF);
        legal_rd = aligned && (reg_id != REG_NONE) && size_ok;
        legal_wr = legal_rd && (reg_id != REG_LVL);
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Two-flop synchronizer for pin levels followed by a per-pin gated
// capture register. A bit updates only while its accept bit is set.
// Assumes pin_in is asynchronous to clk.
module gpio_in_sync #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] accept,
    output logic [PINS-1:0] level
);
    logic [PINS-1:0] sync1;
    logic [PINS-1:0] sync2;

    // Two-stage metastability filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
        end
    end

    // Per-pin capture, held while the pin is not admitted.
    for (genvar i = 0; i < PINS; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n)         level[i] <= 1'b0;
            else if (accept[i]) level[i] <= sync2[i];
        end
    end

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((level ^ $past(level)) & ~$past(accept)) == '0); // R10

endmodule

// File: rtl/gpio_reg_file.sv
// Module gpio_reg_file
// Holds the port registers, applies plain and set/clear writes, and
// produces the registered read data and error pulse.
// Assumes at most one of wr/rd per cycle; a write wins if both are high.
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [BUS_W-1:0] wdata,
    input  reg_id_e          reg_id,
    input  logic             legal_rd,
    input  logic             legal_wr,
    input  logic [PINS-1:0]  level,
    output logic [PINS-1:0]  fer,
    output logic [PINS-1:0]  data,
    output logic [PINS-1:0]  dir,
    output logic [PINS-1:0]  inen,
    output logic [BUS_W-1:0] mux,
    output logic [BUS_W-1:0] rdata,
    output logic             err
);
    logic [PINS-1:0]  wbits;
    logic             do_wr;
    logic             do_rd;
    logic [BUS_W-1:0] rd_mux;

    assign wbits = wdata[PINS-1:0];
    assign do_wr = wr && legal_wr;
    assign do_rd = rd && !wr;

    // Register updates for plain, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fer  <= '0;
            data <= '0;
            dir  <= '0;
            inen <= '0;
            mux  <= '0;
        end else if (do_wr) begin
            case (reg_id)
                REG_FER:    fer  <= wbits;
                REG_DATA:   data <= wbits;
                REG_DSET:   data <= data | wbits;
                REG_DCLR:   data <= data & ~wbits;
                REG_DIRSET: dir  <= dir | wbits;
                REG_DIRCLR: dir  <= dir & ~wbits;
                REG_INEN:   inen <= wbits;
                REG_MUX:    mux  <= wdata;
                default:    ;
            endcase
        end
    end

    // Read selection; aliases return their underlying word.
    always_comb begin
        rd_mux = '0;
        case (reg_id)
            REG_FER:                      rd_mux[PINS-1:0] = fer;
            REG_DATA, REG_DSET, REG_DCLR: rd_mux[PINS-1:0] = data;
            REG_DIRSET, REG_DIRCLR:       rd_mux[PINS-1:0] = dir;
            REG_INEN:                     rd_mux[PINS-1:0] = inen;
            REG_MUX:                      rd_mux = mux;
            REG_LVL:                      rd_mux[PINS-1:0] = level;
            default:                      rd_mux = '0;
        endcase
    end

    // One-cycle response: error pulse and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            err <= (wr && !legal_wr) || (do_rd && !legal_rd);
            if (do_rd) rdata <= legal_rd ? rd_mux : '0;
        end
    end

    AST_DSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && reg_id == REG_DSET) |=> ((data & $past(wbits)) == $past(wbits))); // R3

    AST_DIRCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && reg_id == REG_DIRCLR) |=> ((dir & $past(wbits)) == '0)); // R4

    AST_BAD_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !legal_wr) |=> ($stable(fer) && $stable(data) && $stable(dir)
                               && $stable(inen) && $stable(mux))); // R5

    AST_ERR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr || rd)); // R11

endmodule

// File: rtl/gpio_port_regs.sv
// Module gpio_port_regs
// Top of the GPIO port block: bus decode, register file, pin output
// logic and gated input synchronizer.
// Assumes PINS <= 32 and single-cycle bus strobes.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [31:0]       mux_sel
);
    reg_id_e         reg_id;
    logic            legal_rd;
    logic            legal_wr;
    logic [PINS-1:0] fer;
    logic [PINS-1:0] data;
    logic [PINS-1:0] dir;
    logic [PINS-1:0] inen;
    logic [PINS-1:0] level;
    logic [PINS-1:0] accept;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .size     (bus_size),
        .reg_id   (reg_id),
        .legal_rd (legal_rd),
        .legal_wr (legal_wr)
    );

    gpio_reg_file #(.PINS(PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .reg_id   (reg_id),
        .legal_rd (legal_rd),
        .legal_wr (legal_wr),
        .level    (level),
        .fer      (fer),
        .data     (data),
        .dir      (dir),
        .inen     (inen),
        .mux      (mux_sel),
        .rdata    (bus_rdata),
        .err      (bus_err)
    );

    // Pin drive and input admission per pin.
    always_comb begin
        pin_out = data & ~inen;
        pin_oe  = dir & ~inen;
        accept  = ~dir & inen & fer;
    end

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .accept (accept),
        .level  (level)
    );

endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'd1;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [31:0] mux_sel;

    int n_chk = 0;
    int n_err = 0;
    logic seen;
    logic done = 1'b0;

    typedef struct {
        logic [31:0] rdata;
        logic        chk_rd;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    gpio_port_regs #(.PINS(16), .ADDR_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .mux_sel(mux_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one-cycle strobe; pushes the expected response.
    task automatic acc(input logic w, input logic [5:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] er,
                       input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr = w; bus_rd = !w; bus_addr = a; bus_size = sz; bus_wdata = wd;
        e.rdata = er; e.chk_rd = !w; e.err = ee; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [5:0] a, input logic [15:0] v, input string tag);
        acc(1'b1, a, 2'd1, {16'h0, v}, 32'h0, 1'b0, tag);
    endtask

    task automatic rd16(input logic [5:0] a, input logic [15:0] v, input string tag);
        acc(1'b0, a, 2'd1, 32'h0, {16'h0, v}, 1'b0, tag);
    endtask

    // Monitor: compares the response one cycle after each strobe (R11).
    always @(posedge clk) begin
        seen = bus_wr | bus_rd;
        #1;
        if (seen) begin
            if (sb.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R11 actual response expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " err"}, {31'h0, bus_err}, {31'h0, e.err});
                if (e.chk_rd) check({e.tag, " rdata"}, bus_rdata, e.rdata);
            end
        end else if (rst_n && bus_err) begin
            n_chk++; n_err++;
            $display("FAIL R11 actual err=1 expected err=0 (no strobe)");
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 mux_sel", mux_sel, 32'h0);
        check("R1 bus_err", {31'h0, bus_err}, 32'h0);
        rd16(6'h00, 16'h0, "R1 fer");
        rd16(6'h04, 16'h0, "R1 data");
        rd16(6'h10, 16'h0, "R1 dir");
        rd16(6'h18, 16'h0, "R1 inen");
        acc(1'b0, 6'h1C, 2'd2, 32'h0, 32'h0, 1'b0, "R1 mux");
        rd16(6'h20, 16'h0, "R1 lvl");

        // R2 plain registers
        wr16(6'h00, 16'hA5C3, "R2 wr fer");
        rd16(6'h00, 16'hA5C3, "R2 fer");
        wr16(6'h18, 16'h00FF, "R2 wr inen");
        rd16(6'h18, 16'h00FF, "R2 inen");
        acc(1'b1, 6'h1C, 2'd2, 32'hDEADBEEF, 32'h0, 1'b0, "R2 wr mux");
        acc(1'b0, 6'h1C, 2'd2, 32'h0, 32'hDEADBEEF, 1'b0, "R2 mux");
        check("R2 mux_sel", mux_sel, 32'hDEADBEEF);

        // R3 data with set/clear aliases
        wr16(6'h04, 16'h1234, "R3 wr data");
        wr16(6'h08, 16'h0F00, "R3 set");
        rd16(6'h08, 16'h1F34, "R3 read set alias");
        wr16(6'h0C, 16'h0030, "R3 clear");
        rd16(6'h0C, 16'h1F04, "R3 read clear alias");
        rd16(6'h04, 16'h1F04, "R3 read data");

        // R8 output value masked by input enable
        check("R8 pin_out", {16'h0, pin_out}, 32'h00001F00);

        // R4 direction through aliases only
        wr16(6'h10, 16'hF0F0, "R4 dir set");
        rd16(6'h14, 16'hF0F0, "R4 read clr alias");
        wr16(6'h14, 16'h3000, "R4 dir clr");
        rd16(6'h10, 16'hC0F0, "R4 read set alias");
        wr16(6'h04, 16'h1F04, "R4 data write");
        rd16(6'h14, 16'hC0F0, "R4 dir unchanged");

        // R9 output enable
        check("R9 pin_oe", {16'h0, pin_oe}, 32'h0000C000);

        // R5 access size
        acc(1'b1, 6'h00, 2'd2, 32'h0000FFFF, 32'h0, 1'b1, "R5 fer word write");
        rd16(6'h00, 16'hA5C3, "R5 fer kept");
        acc(1'b1, 6'h1C, 2'd1, 32'h00001111, 32'h0, 1'b1, "R5 mux half write");
        acc(1'b0, 6'h1C, 2'd1, 32'h0, 32'h0, 1'b1, "R5 mux half read");
        acc(1'b0, 6'h1C, 2'd2, 32'h0, 32'hDEADBEEF, 1'b0, "R5 mux kept");
        acc(1'b0, 6'h04, 2'd0, 32'h0, 32'h0, 1'b1, "R5 byte read");
        acc(1'b1, 6'h08, 2'd0, 32'h0000FFFF, 32'h0, 1'b1, "R5 byte set");
        rd16(6'h04, 16'h1F04, "R5 data kept");

        // R6 unmapped and unaligned
        acc(1'b1, 6'h24, 2'd1, 32'h0000FFFF, 32'h0, 1'b1, "R6 wr 0x24");
        acc(1'b0, 6'h3C, 2'd1, 32'h0, 32'h0, 1'b1, "R6 rd 0x3C");
        acc(1'b0, 6'h06, 2'd1, 32'h0, 32'h0, 1'b1, "R6 rd 0x06");
        acc(1'b1, 6'h05, 2'd1, 32'h0000FFFF, 32'h0, 1'b1, "R6 wr 0x05");
        rd16(6'h04, 16'h1F04, "R6 data kept");
        rd16(6'h10, 16'hC0F0, "R6 dir kept");

        // R7 input-level register is read-only
        acc(1'b1, 6'h20, 2'd1, 32'h0000FFFF, 32'h0, 1'b1, "R7 wr lvl");
        rd16(6'h20, 16'h0000, "R7 lvl kept");

        // R10 gated input capture: accept = ~dir & inen & fer
        pin_in = 16'hFFFF;
        repeat (5) @(negedge clk);
        rd16(6'h20, 16'h0003, "R10 partial accept");
        wr16(6'h18, 16'hFFFF, "R10 inen all");
        repeat (5) @(negedge clk);
        rd16(6'h20, 16'h2503, "R10 wider accept");
        check("R8 pin_out all inputs", {16'h0, pin_out}, 32'h0);
        check("R9 pin_oe all inputs", {16'h0, pin_oe}, 32'h0);
        wr16(6'h00, 16'h0001, "R10 fer one");
        pin_in = 16'h0000;
        repeat (5) @(negedge clk);
        rd16(6'h20, 16'h2502, "R10 held bits");

        repeat (3) @(negedge clk);
        check("R11 queue drained", sb.size(), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule